// File: doc/BRIEF.md
# Radio Command-Byte Register Slave

This block is the control-port side of a small packet radio. A host drives it over an 8-bit SPI link in mode 0 (clock idle low, data sampled on the rising clock edge) with an active-low select. Each transaction starts with one command byte. While that byte is shifted in, the block shifts the current status byte out. The command byte either names a register to read or write, or does nothing.

The register space has 32 addresses. Most registers are one byte wide and keep only their defined bits. Three registers hold addresses of up to five bytes, moved least-significant byte first. Their length follows a two-bit width code. Four further pipe address registers store only their lowest byte and take the rest from the pipe 1 address. The status byte combines three sticky event flags, which are cleared by writing ones, with live inputs from the rest of the radio. All register contents appear as parallel outputs for the surrounding logic.

The SPI pins are synchronised into the system clock, which must run well above the SPI clock. The design uses a synchronous active-high reset.

Top module: `radio_spi_regs`

## Requirements
- R1: A command byte whose bits 7:5 are 000 reads the register at address bits 4:0. The data bytes that follow return that register's bytes, lowest byte first. Every byte past the register's length returns 0x00.
- R2: A command byte whose bits 7:5 are 001 writes the register at address bits 4:0. The data bytes that follow are stored in order, lowest byte first. Bytes past the register's length are dropped.
- R3: During the command byte, MISO carries the status byte for any command. The command 0xFF changes no register.
- R4: The status byte is laid out as follows. Bit 7 is 0. Bit 6 is a sticky receive-ready flag, bit 5 a sticky transmit-done flag and bit 4 a sticky retry-limit flag. Each flag is set one clock after a high cycle on its event input. Bits 3:1 equal rx_pipe_i and bit 0 equals tx_full_i. Writing a 1 to bit 6, 5 or 4 of status (address 0x07) clears that flag. An event in the same cycle as the clear wins.
- R5: Addresses 0x0A and 0x0B (receive pipes 0 and 1) and 0x10 (transmit) hold multi-byte addresses. The number of bytes comes from bits 1:0 of address 0x03: code 2 gives 4 bytes, code 3 gives 5 bytes, and codes 0 and 1 give 3 bytes. addr_width_o reports that byte count.
- R6: Addresses 0x0C to 0x0F (receive pipes 2 to 5) store one byte. On rx_addr_o, pipe k occupies bits [40k+39:40k]. For pipes 2 to 5 the upper four bytes equal the upper four bytes of pipe 1, and the low byte is the pipe's own byte.
- R7: Each one-byte register keeps only its defined bits, and writes store data AND mask. The masks are: config 0x00 → 0x7F, 0x01 and 0x02 → 0x3F, 0x03 → 0x03, channel 0x05 → 0x7F, 0x04, 0x06 and 0x0C–0x0F → 0xFF, and payload widths 0x11–0x16 → 0x3F. Payload width of pipe k sits at payload_width_o[8k+7:8k].
- R8: Raising chip select ends the transaction. A write takes effect only for bytes completed before that edge, and a partial trailing byte is discarded.
- R9: Addresses 0x08, 0x09, 0x11–0x1F outside 0x11–0x16, and 0x17–0x1F read as 0x00, and writes to them change nothing.
- R10: After reset every register is zero except address 0x03, which is 0x03. MISO is 0 while chip select is high.
- R11: A command byte that is neither a read (000) nor a write (001) in bits 7:5 changes no register. The bytes that follow it return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | SPI clock, mode 0 |
| csn_i | input | 1 | SPI select, active low |
| mosi_i | input | 1 | SPI data in, MSB first |
| miso_o | output | 1 | SPI data out, MSB first |
| evt_rx_ready_i | input | 1 | Pulse that sets status bit 6 |
| evt_tx_done_i | input | 1 | Pulse that sets status bit 5 |
| evt_retry_max_i | input | 1 | Pulse that sets status bit 4 |
| rx_pipe_i | input | 3 | Live receive pipe number, status bits 3:1 |
| tx_full_i | input | 1 | Live transmit-full flag, status bit 0 |
| status_o | output | 8 | Current status byte |
| config_o | output | 8 | Config register (address 0x00) |
| auto_ack_o | output | 6 | Per-pipe auto-acknowledge enables (0x01) |
| rx_enable_o | output | 6 | Per-pipe receive enables (0x02) |
| addr_width_o | output | 3 | Address length in bytes, 3 to 5 |
| retry_o | output | 8 | Retransmit setup (0x04) |
| channel_o | output | 8 | RF channel (0x05) |
| rf_setup_o | output | 8 | RF setup (0x06) |
| tx_addr_o | output | 40 | Transmit address (0x10) |
| rx_addr_o | output | 240 | Receive addresses of pipes 0 to 5 |
| payload_width_o | output | 48 | Payload widths of pipes 0 to 5 |

## Verification
Each SPI pin passes two synchroniser flops before edge detection. A MISO bit therefore settles about three system clocks after the SCK falling edge or the select falling edge that launches it. A written register or a cleared flag lands about three clocks after the eighth rising SCK edge of its data byte. The bench holds each SCK phase for four clocks and samples MISO on the falling system-clock edge just before it raises SCK. It reads the parallel outputs only after select has been high for eight more clocks. Event pulses are checked through a status transaction that starts after the pulse, never within the same clock.

// File: rtl/radio_spi_pkg.sv
package radio_spi_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int REG_COUNT  = 32;
    localparam int REG_AW     = $clog2(REG_COUNT);
    localparam int BYTE_W     = 8;
    localparam int WIDE_MAX   = 5;
    localparam int WIDE_SLOTS = 3;
    localparam int PIPES      = 6;
    localparam int IDX_W      = 3;
    localparam int ADDR_W     = WIDE_MAX * BYTE_W;
    localparam int LEN_W      = 3;

    localparam logic [2:0]        OPC_READ  = 3'b000;
    localparam logic [2:0]        OPC_WRITE = 3'b001;

    localparam logic [REG_AW-1:0] A_CONFIG  = 5'h00;
    localparam logic [REG_AW-1:0] A_AUTOACK = 5'h01;
    localparam logic [REG_AW-1:0] A_RXEN    = 5'h02;
    localparam logic [REG_AW-1:0] A_AWIDTH  = 5'h03;
    localparam logic [REG_AW-1:0] A_RETRY   = 5'h04;
    localparam logic [REG_AW-1:0] A_CHAN    = 5'h05;
    localparam logic [REG_AW-1:0] A_RFSET   = 5'h06;
    localparam logic [REG_AW-1:0] A_STATUS  = 5'h07;
    localparam logic [REG_AW-1:0] A_RXP0    = 5'h0A;
    localparam logic [REG_AW-1:0] A_RXP1    = 5'h0B;
    localparam logic [REG_AW-1:0] A_RXP2    = 5'h0C;
    localparam logic [REG_AW-1:0] A_TXADR   = 5'h10;
    localparam logic [REG_AW-1:0] A_PW0     = 5'h11;

    typedef enum logic [1:0] {RK_NONE, RK_BYTE, RK_STATUS, RK_WIDE} reg_kind_e;
    typedef enum logic [1:0] {OP_IDLE, OP_RD, OP_WR} cmd_op_e;

    typedef struct packed {
        logic              en;
        logic [REG_AW-1:0] addr;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic reg_kind_e kind_of(input logic [REG_AW-1:0] a);
        if (a == A_STATUS)                                 return RK_STATUS;
        if (a == A_RXP0 || a == A_RXP1 || a == A_TXADR)    return RK_WIDE;
        if (a inside {[5'h00:5'h06], [5'h0C:5'h0F], [5'h11:5'h16]}) return RK_BYTE;
        return RK_NONE;
    endfunction

    function automatic logic [BYTE_W-1:0] mask_of(input logic [REG_AW-1:0] a);
        case (a)
            A_CONFIG, A_CHAN:  return 8'h7F;
            A_AUTOACK, A_RXEN: return 8'h3F;
            A_AWIDTH:          return 8'h03;
            default:           return (a >= A_PW0) ? 8'h3F : 8'hFF;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] reset_of(input logic [REG_AW-1:0] a);
        return (a == A_AWIDTH) ? 8'h03 : 8'h00;
    endfunction

    function automatic logic [1:0] wide_slot(input logic [REG_AW-1:0] a);
        case (a)
            A_RXP0:  return 2'd0;
            A_RXP1:  return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] addr_len(input logic [1:0] code);
        case (code)
            2'd2:    return 3'd4;
            2'd3:    return 3'd5;
            default: return 3'd3;
        endcase
    endfunction

    function automatic cmd_op_e decode_op(input logic [BYTE_W-1:0] cmd);
        if (cmd[7:5] == OPC_READ)  return OP_RD;
        if (cmd[7:5] == OPC_WRITE) return OP_WR;
        return OP_IDLE;
    endfunction
endpackage

// File: rtl/radio_spi_link.sv
module radio_spi_link
    import radio_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sck_i,
    input  logic              csn_i,
    input  logic              mosi_i,
    input  logic [BYTE_W-1:0] status_i,
    input  logic [BYTE_W-1:0] next_i,
    output logic              start_o,
    output logic              byte_vld_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              miso_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CNT_W = $clog2(BYTE_W);

    logic [SYNC_STAGES:0]   sck_pipe;
    logic [SYNC_STAGES:0]   csn_pipe;
    logic [SYNC_STAGES-1:0] mosi_pipe;
    logic                   sck_rise, sck_fall, active, mosi_s;
    logic [CNT_W-1:0]       bit_cnt;
    logic [BYTE_W-1:0]      in_sh, out_sh;
    logic                   fresh;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sck_pipe  <= '0;
            csn_pipe  <= '1;
            mosi_pipe <= '0;
        end else begin
            sck_pipe  <= {sck_pipe[SYNC_STAGES-1:0], sck_i};
            csn_pipe  <= {csn_pipe[SYNC_STAGES-1:0], csn_i};
            mosi_pipe <= {mosi_pipe[SYNC_STAGES-2:0], mosi_i};
        end
    end

    assign active   = ~csn_pipe[SYNC_STAGES-1];
    assign start_o  = csn_pipe[SYNC_STAGES] & ~csn_pipe[SYNC_STAGES-1];
    assign sck_rise = sck_pipe[SYNC_STAGES-1] & ~sck_pipe[SYNC_STAGES];
    assign sck_fall = ~sck_pipe[SYNC_STAGES-1] & sck_pipe[SYNC_STAGES];
    assign mosi_s   = mosi_pipe[SYNC_STAGES-1];

    assign byte_vld_o = active && sck_rise && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign byte_o     = {in_sh[BYTE_W-2:0], mosi_s};
    assign miso_o     = active & out_sh[BYTE_W-1];

    // receive side: bits counted only while selected
    always_ff @(posedge clk_i) begin
        if (rst_i || !active) begin
            bit_cnt <= '0;
            in_sh   <= '0;
        end else if (sck_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            in_sh   <= byte_o;
        end
    end

    // transmit side: reload after a full byte, skip the shift on the next fall
    always_ff @(posedge clk_i) begin
        if (rst_i || !active) begin
            out_sh <= '0;
            fresh  <= 1'b0;
        end else if (start_o) begin
            out_sh <= status_i;
            fresh  <= 1'b0;
        end else if (byte_vld_o) begin
            out_sh <= next_i;
            fresh  <= 1'b1;
        end else if (sck_fall) begin
            if (fresh) fresh <= 1'b0;
            else       out_sh <= {out_sh[BYTE_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/radio_cmd_engine.sv
module radio_cmd_engine
    import radio_spi_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [REG_AW-1:0] rd_addr_o,
    output logic [IDX_W-1:0]  rd_idx_o,
    output logic [BYTE_W-1:0] next_o,
    output wr_req_t           wr_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic              first_q;
    cmd_op_e           op_q, op_new;
    logic [REG_AW-1:0] addr_q;
    logic [IDX_W-1:0]  idx_q, idx_nxt;

    assign op_new  = decode_op(byte_i);
    assign idx_nxt = (idx_q == '1) ? idx_q : idx_q + 1'b1;

    always_comb begin
        if (first_q) begin
            rd_addr_o = byte_i[REG_AW-1:0];
            rd_idx_o  = '0;
            next_o    = (op_new == OP_RD) ? rd_data_i : '0;
        end else begin
            rd_addr_o = addr_q;
            rd_idx_o  = idx_nxt;
            next_o    = (op_q == OP_RD) ? rd_data_i : '0;
        end
    end

    always_comb begin
        wr_o.en   = byte_vld_i && !first_q && (op_q == OP_WR);
        wr_o.addr = addr_q;
        wr_o.idx  = idx_q;
        wr_o.data = byte_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            first_q <= 1'b1;
            op_q    <= OP_IDLE;
            addr_q  <= '0;
            idx_q   <= '0;
        end else if (start_i) begin
            first_q <= 1'b1;
            op_q    <= OP_IDLE;
            idx_q   <= '0;
        end else if (byte_vld_i) begin
            if (first_q) begin
                first_q <= 1'b0;
                op_q    <= op_new;
                addr_q  <= byte_i[REG_AW-1:0];
                idx_q   <= '0;
            end else begin
                idx_q   <= idx_nxt;
            end
        end
    end
endmodule

// File: rtl/radio_reg_bank.sv
module radio_reg_bank
    import radio_spi_pkg::*;
(
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  wr_req_t                   wr_i,
    input  logic [REG_AW-1:0]         rd_addr_i,
    input  logic [IDX_W-1:0]          rd_idx_i,
    output logic [BYTE_W-1:0]         rd_data_o,
    input  logic                      evt_rx_i,
    input  logic                      evt_tx_i,
    input  logic                      evt_rt_i,
    input  logic [2:0]                rx_pipe_i,
    input  logic                      tx_full_i,
    output logic [BYTE_W-1:0]         status_o,
    output logic [BYTE_W-1:0]         config_o,
    output logic [PIPES-1:0]          auto_ack_o,
    output logic [PIPES-1:0]          rx_enable_o,
    output logic [LEN_W-1:0]          addr_width_o,
    output logic [BYTE_W-1:0]         retry_o,
    output logic [BYTE_W-1:0]         channel_o,
    output logic [BYTE_W-1:0]         rf_setup_o,
    output logic [ADDR_W-1:0]         tx_addr_o,
    output logic [PIPES*ADDR_W-1:0]   rx_addr_o,
    output logic [PIPES*BYTE_W-1:0]   payload_width_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [BYTE_W-1:0] byte_q [REG_COUNT];
    logic [BYTE_W-1:0] wide_q [WIDE_SLOTS][WIDE_MAX];
    logic [2:0]        flag_q, flag_clr, flag_set;
    logic [LEN_W-1:0]  cur_len;
    logic [ADDR_W-1:0] wide_vec [WIDE_SLOTS];

    assign cur_len = addr_len(byte_q[A_AWIDTH][1:0]);

    // one-byte registers: masked store on the first data byte
    always_ff @(posedge clk_i) begin
        for (int a = 0; a < REG_COUNT; a++) begin
            if (rst_i)
                byte_q[a] <= reset_of(REG_AW'(a));
            else if (wr_i.en && wr_i.addr == REG_AW'(a) && wr_i.idx == '0
                     && kind_of(REG_AW'(a)) == RK_BYTE)
                byte_q[a] <= wr_i.data & mask_of(REG_AW'(a));
        end
    end

    // multi-byte address registers: byte lane follows the data index
    always_ff @(posedge clk_i) begin
        for (int s = 0; s < WIDE_SLOTS; s++) begin
            for (int k = 0; k < WIDE_MAX; k++) begin
                if (rst_i)
                    wide_q[s][k] <= '0;
                else if (wr_i.en && kind_of(wr_i.addr) == RK_WIDE
                         && wide_slot(wr_i.addr) == 2'(s)
                         && wr_i.idx == IDX_W'(k) && LEN_W'(k) < cur_len)
                    wide_q[s][k] <= wr_i.data;
            end
        end
    end

    // sticky flags {rx, tx, retry}: set beats clear
    assign flag_set = {evt_rx_i, evt_tx_i, evt_rt_i};
    assign flag_clr = (wr_i.en && wr_i.addr == A_STATUS && wr_i.idx == '0)
                      ? wr_i.data[6:4] : 3'b000;

    always_ff @(posedge clk_i) begin
        if (rst_i) flag_q <= '0;
        else       flag_q <= (flag_q & ~flag_clr) | flag_set;
    end

    assign status_o = {1'b0, flag_q, rx_pipe_i, tx_full_i};

    always_comb begin
        rd_data_o = '0;
        case (kind_of(rd_addr_i))
            RK_BYTE:   if (rd_idx_i == '0) rd_data_o = byte_q[rd_addr_i];
            RK_STATUS: if (rd_idx_i == '0) rd_data_o = status_o;
            RK_WIDE: begin
                for (int k = 0; k < WIDE_MAX; k++)
                    if (rd_idx_i == IDX_W'(k) && LEN_W'(k) < cur_len)
                        rd_data_o = wide_q[wide_slot(rd_addr_i)][k];
            end
            default:   rd_data_o = '0;
        endcase
    end

    genvar s, p;
    generate
        for (s = 0; s < WIDE_SLOTS; s++) begin : g_wide
            for (p = 0; p < WIDE_MAX; p++) begin : g_lane
                assign wide_vec[s][p*BYTE_W +: BYTE_W] = wide_q[s][p];
            end
        end

        for (p = 0; p < PIPES; p++) begin : g_pipe
            if (p < 2) begin : g_full
                assign rx_addr_o[p*ADDR_W +: ADDR_W] = wide_vec[p];
            end else begin : g_short
                assign rx_addr_o[p*ADDR_W +: ADDR_W] =
                    {wide_vec[1][ADDR_W-1:BYTE_W], byte_q[int'(A_RXP2) + p - 2]};
            end
            assign payload_width_o[p*BYTE_W +: BYTE_W] = byte_q[int'(A_PW0) + p];
        end
    endgenerate

    assign tx_addr_o    = wide_vec[wide_slot(A_TXADR)];
    assign config_o     = byte_q[A_CONFIG];
    assign auto_ack_o   = byte_q[A_AUTOACK][PIPES-1:0];
    assign rx_enable_o  = byte_q[A_RXEN][PIPES-1:0];
    assign addr_width_o = cur_len;
    assign retry_o      = byte_q[A_RETRY];
    assign channel_o    = byte_q[A_CHAN];
    assign rf_setup_o   = byte_q[A_RFSET];
endmodule

// File: rtl/radio_spi_regs.sv
module radio_spi_regs
    import radio_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    sck_i,
    input  logic                    csn_i,
    input  logic                    mosi_i,
    output logic                    miso_o,
    input  logic                    evt_rx_ready_i,
    input  logic                    evt_tx_done_i,
    input  logic                    evt_retry_max_i,
    input  logic [2:0]              rx_pipe_i,
    input  logic                    tx_full_i,
    output logic [BYTE_W-1:0]       status_o,
    output logic [BYTE_W-1:0]       config_o,
    output logic [PIPES-1:0]        auto_ack_o,
    output logic [PIPES-1:0]        rx_enable_o,
    output logic [LEN_W-1:0]        addr_width_o,
    output logic [BYTE_W-1:0]       retry_o,
    output logic [BYTE_W-1:0]       channel_o,
    output logic [BYTE_W-1:0]       rf_setup_o,
    output logic [ADDR_W-1:0]       tx_addr_o,
    output logic [PIPES*ADDR_W-1:0] rx_addr_o,
    output logic [PIPES*BYTE_W-1:0] payload_width_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic              link_start, link_byte_vld;
    logic [BYTE_W-1:0] link_byte, next_byte, rd_data;
    logic [REG_AW-1:0] rd_addr;
    logic [IDX_W-1:0]  rd_idx;
    wr_req_t           wr_req;

    radio_spi_link #(.SYNC_STAGES(SYNC_STAGES)) i_link (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .sck_i      (sck_i),
        .csn_i      (csn_i),
        .mosi_i     (mosi_i),
        .status_i   (status_o),
        .next_i     (next_byte),
        .start_o    (link_start),
        .byte_vld_o (link_byte_vld),
        .byte_o     (link_byte),
        .miso_o     (miso_o)
    );

    radio_cmd_engine i_engine (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .start_i    (link_start),
        .byte_vld_i (link_byte_vld),
        .byte_i     (link_byte),
        .rd_data_i  (rd_data),
        .rd_addr_o  (rd_addr),
        .rd_idx_o   (rd_idx),
        .next_o     (next_byte),
        .wr_o       (wr_req)
    );

    radio_reg_bank i_bank (
        .clk_i           (clk_i),
        .rst_i           (rst_i),
        .wr_i            (wr_req),
        .rd_addr_i       (rd_addr),
        .rd_idx_i        (rd_idx),
        .rd_data_o       (rd_data),
        .evt_rx_i        (evt_rx_ready_i),
        .evt_tx_i        (evt_tx_done_i),
        .evt_rt_i        (evt_retry_max_i),
        .rx_pipe_i       (rx_pipe_i),
        .tx_full_i       (tx_full_i),
        .status_o        (status_o),
        .config_o        (config_o),
        .auto_ack_o      (auto_ack_o),
        .rx_enable_o     (rx_enable_o),
        .addr_width_o    (addr_width_o),
        .retry_o         (retry_o),
        .channel_o       (channel_o),
        .rf_setup_o      (rf_setup_o),
        .tx_addr_o       (tx_addr_o),
        .rx_addr_o       (rx_addr_o),
        .payload_width_o (payload_width_o)
    );
endmodule

// File: rtl/radio_spi_chk.sv
module radio_spi_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic        clk_i,
    input logic        rst_i,
    input logic        csn_i,
    input logic        miso_o,
    input logic        evt_rx_ready_i,
    input logic        evt_tx_done_i,
    input logic        link_byte_vld,
    input logic [7:0]  status_o,
    input logic [7:0]  config_o,
    input logic [2:0]  addr_width_o,
    input logic [47:0] payload_width_o
);
    timeunit 1ns;
    timeprecision 1ps;

    int unsigned csn_hi_cnt;

    always_ff @(posedge clk_i) begin
        if (rst_i || !csn_i)                       csn_hi_cnt <= 0;
        else if (csn_hi_cnt <= SYNC_STAGES)        csn_hi_cnt <= csn_hi_cnt + 1;
    end

    // R4
    rx_flag_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_rx_ready_i |=> status_o[6]);

    // R4
    tx_flag_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_tx_done_i |=> status_o[5]);

    // R4
    rx_flag_clear_src_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(status_o[6]) |-> $past(link_byte_vld));

    // R5
    width_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        addr_width_o >= 3'd3 && addr_width_o <= 3'd5);

    // R7
    pw_mask_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (payload_width_o & 48'hC0C0_C0C0_C0C0) == 48'h0);

    // R8
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !link_byte_vld |=> $stable(config_o));

    // R10
    miso_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (csn_hi_cnt > SYNC_STAGES) |-> !miso_o);
endmodule

bind radio_spi_regs radio_spi_chk #(.SYNC_STAGES(SYNC_STAGES)) i_chk (
    .clk_i           (clk_i),
    .rst_i           (rst_i),
    .csn_i           (csn_i),
    .miso_o          (miso_o),
    .evt_rx_ready_i  (evt_rx_ready_i),
    .evt_tx_done_i   (evt_tx_done_i),
    .link_byte_vld   (link_byte_vld),
    .status_o        (status_o),
    .config_o        (config_o),
    .addr_width_o    (addr_width_o),
    .payload_width_o (payload_width_o)
);

// File: tb/test_radio_spi_regs.sv
module test_radio_spi_regs;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int H = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic ev_rx = 1'b0, ev_tx = 1'b0, ev_rt = 1'b0;
    logic [2:0] rx_pipe = 3'd3;
    logic tx_full = 1'b1;
    logic miso;
    logic [7:0] status, cfg, retry, chan, rfset;
    logic [5:0] aack, rxen;
    logic [2:0] awid;
    logic [39:0] txa;
    logic [239:0] rxa;
    logic [47:0] pw;

    always #4 clk = ~clk;

    radio_spi_regs i_radio_spi_regs (
        .clk_i(clk), .rst_i(rst), .sck_i(sck), .csn_i(csn), .mosi_i(mosi), .miso_o(miso),
        .evt_rx_ready_i(ev_rx), .evt_tx_done_i(ev_tx), .evt_retry_max_i(ev_rt),
        .rx_pipe_i(rx_pipe), .tx_full_i(tx_full), .status_o(status), .config_o(cfg),
        .auto_ack_o(aack), .rx_enable_o(rxen), .addr_width_o(awid), .retry_o(retry),
        .channel_o(chan), .rf_setup_o(rfset), .tx_addr_o(txa), .rx_addr_o(rxa),
        .payload_width_o(pw)
    );

    int checks = 0, errors = 0;
    logic [7:0] tx_buf [8];
    logic [7:0] rx_buf [8];
    logic [7:0] mdl_byte [32];
    logic [7:0] mdl_wide [3][5];
    logic [2:0] mdl_flags;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int m_kind(input int a);
        if (a == 7) return 2;
        if (a == 10 || a == 11 || a == 16) return 3;
        if (a <= 6 || (a >= 12 && a <= 15) || (a >= 17 && a <= 22)) return 1;
        return 0;
    endfunction

    function automatic logic [7:0] m_mask(input int a);
        if (a == 0 || a == 5) return 8'h7F;
        if (a == 1 || a == 2 || a >= 17) return 8'h3F;
        if (a == 3) return 8'h03;
        return 8'hFF;
    endfunction

    function automatic int m_len();
        case (mdl_byte[3][1:0])
            2'd2: return 4;
            2'd3: return 5;
            default: return 3;
        endcase
    endfunction

    function automatic int m_slot(input int a);
        return (a == 10) ? 0 : (a == 11) ? 1 : 2;
    endfunction

    function automatic logic [7:0] m_status();
        return {1'b0, mdl_flags, rx_pipe, tx_full};
    endfunction

    function automatic logic [7:0] m_read(input int a, input int idx);
        case (m_kind(a))
            1: return (idx == 0) ? mdl_byte[a] : 8'h00;
            2: return (idx == 0) ? m_status() : 8'h00;
            3: return (idx < m_len()) ? mdl_wide[m_slot(a)][idx] : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_write(input int a, input int idx, input logic [7:0] d);
        case (m_kind(a))
            1: if (idx == 0) mdl_byte[a] = d & m_mask(a);
            2: if (idx == 0) mdl_flags = mdl_flags & ~d[6:4];
            3: if (idx < m_len()) mdl_wide[m_slot(a)][idx] = d;
            default: ;
        endcase
    endtask

    function automatic logic [39:0] m_wide_vec(input int s);
        return {mdl_wide[s][4], mdl_wide[s][3], mdl_wide[s][2], mdl_wide[s][1], mdl_wide[s][0]};
    endfunction

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_txn(input int nbytes, input int tail_bits);
        csn = 1'b0;
        waitn(H);
        for (int b = 0; b < nbytes; b++) begin
            for (int i = 7; i >= 0; i--) begin
                mosi = tx_buf[b][i];
                waitn(H);
                rx_buf[b][i] = miso;
                sck = 1'b1;
                waitn(H);
                sck = 1'b0;
            end
        end
        for (int i = 0; i < tail_bits; i++) begin
            mosi = tx_buf[nbytes][7-i];
            waitn(H);
            sck = 1'b1;
            waitn(H);
            sck = 1'b0;
        end
        waitn(H);
        csn = 1'b1;
        waitn(2 * H);
    endtask

    task automatic wr_reg(input int a, input int n, input string tag);
        logic [7:0] st;
        st = m_status();
        tx_buf[0] = 8'h20 | 8'(a);
        spi_txn(n + 1, 0);
        chk({tag, " status byte"}, 64'(rx_buf[0]), 64'(st));
        for (int k = 0; k < n; k++) m_write(a, k, tx_buf[k + 1]);
    endtask

    task automatic rd_reg(input int a, input int n, input string tag);
        logic [7:0] st;
        st = m_status();
        tx_buf[0] = 8'(a);
        for (int k = 1; k <= n; k++) tx_buf[k] = 8'hFF;
        spi_txn(n + 1, 0);
        chk({tag, " status byte"}, 64'(rx_buf[0]), 64'(st));
        for (int k = 0; k < n; k++)
            chk($sformatf("%s addr %0h byte %0d", tag, a, k), 64'(rx_buf[k + 1]), 64'(m_read(a, k)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        for (int a = 0; a < 32; a++) mdl_byte[a] = 8'h00;
        mdl_byte[3] = 8'h03;
        for (int s = 0; s < 3; s++) for (int k = 0; k < 5; k++) mdl_wide[s][k] = 8'h00;
        mdl_flags = 3'b000;

        waitn(6);
        rst = 1'b0;
        waitn(6);

        // R10 reset state
        chk("R10 config after reset", 64'(cfg), 64'h00);
        chk("R10 width after reset", 64'(awid), 64'd5);
        chk("R10 miso idle", 64'(miso), 64'd0);
        chk("R10 tx addr after reset", 64'(txa), 64'h0);
        chk("R4 live status bits", 64'(status), 64'h07);

        // R3 no-op returns status and changes nothing
        tx_buf[0] = 8'hFF;
        spi_txn(1, 0);
        chk("R3 nop status", 64'(rx_buf[0]), 64'(m_status()));
        chk("R10 miso after select high", 64'(miso), 64'd0);

        // R4 event sets sticky flag, then write-one clears
        @(negedge clk); ev_rx = 1'b1; ev_rt = 1'b1;
        @(negedge clk); ev_rx = 1'b0; ev_rt = 1'b0;
        mdl_flags = 3'b101;
        tx_buf[0] = 8'hFF;
        spi_txn(1, 0);
        chk("R4 flags set by events", 64'(rx_buf[0]), 64'h57);
        tx_buf[1] = 8'h40;
        wr_reg(7, 1, "R4 clear rx flag");
        chk("R4 only written flag cleared", 64'(status), 64'h17);
        rd_reg(7, 2, "R4 status read");

        // R7 config mask and masked widths
        tx_buf[1] = 8'hFF;
        wr_reg(0, 1, "R7 config write");
        chk("R7 config masked", 64'(cfg), 64'h7F);
        for (int p = 0; p < 6; p++) begin
            tx_buf[1] = 8'hFF;
            wr_reg(17 + p, 1, "R7 width write");
        end
        chk("R7 payload widths masked", 64'(pw), 64'h3F3F3F3F3F3F);
        rd_reg(5, 1, "R7 channel");

        // R5 five-byte transmit address, lowest byte first
        for (int k = 1; k <= 5; k++) tx_buf[k] = 8'(8'h10 * k + k);
        wr_reg(16, 5, "R5 tx write");
        chk("R5 tx addr output", 64'(txa), 64'(m_wide_vec(2)));
        rd_reg(16, 6, "R5 tx read");

        // R5 width code 1 limits to three bytes
        tx_buf[1] = 8'h01;
        wr_reg(3, 1, "R5 width code");
        chk("R5 width three", 64'(awid), 64'd3);
        for (int k = 1; k <= 5; k++) tx_buf[k] = 8'(8'hA0 + k);
        wr_reg(11, 5, "R5 pipe1 short write");
        rd_reg(11, 5, "R5 pipe1 short read");
        chk("R5 pipe1 upper bytes untouched", 64'(rxa[40 +: 40]), 64'(m_wide_vec(1)));
        tx_buf[1] = 8'h03;
        wr_reg(3, 1, "R5 width restore");
        for (int k = 1; k <= 5; k++) tx_buf[k] = 8'(8'hC0 + k);
        wr_reg(11, 5, "R5 pipe1 full write");

        // R6 short pipes inherit upper bytes from pipe 1
        tx_buf[1] = 8'hAB;
        wr_reg(12, 1, "R6 pipe2 write");
        chk("R6 pipe2 composed", 64'(rxa[80 +: 40]), 64'({m_wide_vec(1)[39:8], 8'hAB}));
        chk("R6 pipe5 composed", 64'(rxa[200 +: 40]), 64'({m_wide_vec(1)[39:8], 8'h00}));
        rd_reg(12, 2, "R6 pipe2 read");

        // R8 partial trailing byte discarded
        tx_buf[0] = 8'h25; tx_buf[1] = 8'h55;
        spi_txn(1, 5);
        chk("R8 channel unchanged by partial byte", 64'(chan), 64'(mdl_byte[5]));
        tx_buf[0] = 8'h30; tx_buf[1] = 8'h11; tx_buf[2] = 8'h22; tx_buf[3] = 8'h33;
        spi_txn(3, 4);
        m_write(16, 0, 8'h11); m_write(16, 1, 8'h22);
        chk("R8 tx addr two full bytes only", 64'(txa), 64'(m_wide_vec(2)));

        // R9 unimplemented addresses
        tx_buf[1] = 8'h5A;
        wr_reg(30, 1, "R9 unimpl write");
        rd_reg(30, 1, "R9 unimpl read");
        rd_reg(8, 1, "R9 addr 08 read");

        // R11 other opcode is ignored
        tx_buf[0] = 8'hA0; tx_buf[1] = 8'h12;
        spi_txn(2, 0);
        chk("R11 status on unknown command", 64'(rx_buf[0]), 64'(m_status()));
        chk("R11 following byte zero", 64'(rx_buf[1]), 64'h00);
        chk("R11 config unchanged", 64'(cfg), 64'(mdl_byte[0]));

        // R1 R2 random writes and read-backs against the model
        for (int it = 0; it < 80; it++) begin
            int a, n;
            a = int'($urandom % 32);
            n = 1 + int'($urandom % 6);
            for (int k = 1; k <= n; k++) tx_buf[k] = 8'($urandom);
            wr_reg(a, n, "R2 random write");
            rd_reg(a, n + 1, "R1 random read");
        end
        chk("R2 config output", 64'(cfg), 64'(mdl_byte[0]));
        chk("R2 width output", 64'(awid), 64'(m_len()));
        chk("R2 tx addr output", 64'(txa), 64'(m_wide_vec(2)));
        chk("R6 pipe3 output", 64'(rxa[120 +: 40]), 64'({m_wide_vec(1)[39:8], mdl_byte[13]}));
        chk("R2 enables output", 64'({aack, rxen}), 64'({mdl_byte[1][5:0], mdl_byte[2][5:0]}));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule